// File: doc/BRIEF.md
# Serial Modulator Configuration Register

This block takes a 23-bit control word for a burst QPSK transmitter over a three-line serial port (clock, data, enable) and turns it into a parallel set of configuration fields. These are the synthesizer divider values, bias enable, pump current, pump three-state select, output attenuation and a filter test bit. The serial lines are brought into the system clock domain through a synchronizer chain and oversampled there. A bit is taken on every falling edge of the serial clock while the enable line is high, least significant bit first.

When the enable line falls, the block checks whether exactly 23 bits arrived. If so, the word is decoded. The prescaler value must be 0 to 5, the feedback count must be 41 to 103, and the reserved bits must be zero. A legal word replaces the held configuration. Any other word leaves the held configuration as it was and clears the valid flag. A frame of the wrong length is discarded and raises a framing error flag.

Top module: `serial_mod_cfg`

## Requirements
- R1: While reset is high, and after it until the first accepted word, every configuration output is 0 (synthesizer disabled), `wordOk` is 0 and `frameErr` is 0.
- R2: Serial clock falling edges that occur while the enable line is low capture nothing and change no output.
- R3: The first bit shifted in becomes bit D0 of the word, so the word arrives LSB-first.
- R4: Field mapping: `presA` = D2..D0, `fbM` = D9..D3, `synthEn` = D10, `pumpHi` = D11, `triDis` = D12, `atten` = D18..D13, reserved = D21..D19, `filterOff` = D22, with the higher index as MSB in each field.
- R5: The outputs change only after the enable line falls. While the enable line stays high, even after 23 bits have arrived, they keep their earlier values.
- R6: If the count of captured bits at the enable falling edge differs from 23, the word is discarded. `frameErr` becomes 1, `wordOk` becomes 0 and the configuration is unchanged.
- R7: A word with `presA` above 5 is rejected: the configuration is kept and `wordOk` becomes 0.
- R8: A word with `fbM` below 41 or above 103 is rejected in the same way. The values 41 and 103 are legal.
- R9: A word with nonzero reserved bits is rejected in the same way.
- R10: A full-length legal word loads all fields, sets `wordOk` to 1 and clears `frameErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgSclk | input | 1 | Serial clock; data taken on its falling edge |
| cfgSdata | input | 1 | Serial data, LSB first |
| cfgSen | input | 1 | Frame enable, active high; its falling edge ends the frame |
| presA | output | 3 | Prescaler value |
| fbM | output | 7 | Feedback counter value |
| synthEn | output | 1 | Synthesizer bias enable (0 = low power) |
| pumpHi | output | 1 | Charge-pump current select (1 = higher) |
| triDis | output | 1 | 1 disables pump three-state on coincident up/down |
| atten | output | 6 | Attenuation code in 1 dB steps |
| filterOff | output | 1 | 1 disables the digital filter (test mode) |
| wordOk | output | 1 | Last finished frame was full length and legal |
| frameErr | output | 1 | Last finished frame had the wrong bit count |

## Verification
The checker tests some properties on every cycle. The held fields change only together with a set `wordOk` and a clear `frameErr`. The two flags are never set at the same time. A held configuration always has a legal prescaler and feedback count. Nothing changes while the enable line has been high. Bit order, field placement, the exact 23-bit boundary (22 and 24 bits), the range edges 41/103 and 5/6, and the ignoring of clocks with the enable line low are shown only by the bench's directed frames. Those frames are compared against a behavioural model.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int WORD_LEN = 23;

  typedef struct packed {
    logic [2:0] presA;
    logic [6:0] fbM;
    logic       synthEn;
    logic       pumpHi;
    logic       triDis;
    logic [5:0] atten;
    logic       filterOff;
  } cfg_t;

  typedef struct packed {
    logic shiftBit;
    logic bitVal;
    logic commit;
    logic abort;
  } strobe_t;
endpackage

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = WORD_LEN
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    sclkIn,
  input  logic    sdataIn,
  input  logic    senIn,
  output strobe_t strobes
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  // each stage carries {sclk, sdata, sen}
  logic [2:0] syncReg [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) syncReg[g] <= '0;
        else     syncReg[g] <= {sclkIn, sdataIn, senIn};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) syncReg[g] <= '0;
        else     syncReg[g] <= syncReg[g-1];
      end
    end
  end

  logic sclkS, dataS, enS;
  assign {sclkS, dataS, enS} = syncReg[SYNC_STAGES-1];

  logic sclkQ, enQ;
  logic [CNT_W-1:0] bitCnt;
  logic sclkFall, enFall;

  assign sclkFall = sclkQ & ~sclkS;
  assign enFall   = enQ & ~enS;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkQ  <= 1'b0;
      enQ    <= 1'b0;
      bitCnt <= '0;
    end else begin
      sclkQ <= sclkS;
      enQ   <= enS;
      if (enFall)
        bitCnt <= '0;
      else if (enS && sclkFall && bitCnt != CNT_MAX)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.shiftBit = enS & sclkFall;
    strobes.bitVal   = dataS;
    strobes.commit   = enFall & (bitCnt == CNT_FULL);
    strobes.abort    = enFall & (bitCnt != CNT_FULL);
  end
endmodule

// File: rtl/smc_dp.sv
module smc_dp
  import smc_pkg::*;
#(
  parameter int A_MAX = 5,
  parameter int M_MIN = 41,
  parameter int M_MAX = 103
) (
  input  logic    clk,
  input  logic    rst,
  input  strobe_t strobes,
  output cfg_t    cfg,
  output logic    wordOk,
  output logic    frameErr
);
  logic [WORD_LEN-1:0] shiftReg;
  cfg_t       cand;
  logic [2:0] rsvBits;
  logic       legal;

  always_comb begin
    cand.presA     = shiftReg[2:0];
    cand.fbM       = shiftReg[9:3];
    cand.synthEn   = shiftReg[10];
    cand.pumpHi    = shiftReg[11];
    cand.triDis    = shiftReg[12];
    cand.atten     = shiftReg[18:13];
    rsvBits        = shiftReg[21:19];
    cand.filterOff = shiftReg[22];
    legal = (int'(cand.presA) <= A_MAX) &&
            (int'(cand.fbM) >= M_MIN) && (int'(cand.fbM) <= M_MAX) &&
            (rsvBits == 3'b000);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      cfg      <= '0;
      wordOk   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (strobes.shiftBit)
        shiftReg <= {strobes.bitVal, shiftReg[WORD_LEN-1:1]};
      if (strobes.commit) begin
        if (legal) cfg <= cand;
        wordOk   <= legal;
        frameErr <= 1'b0;
      end else if (strobes.abort) begin
        wordOk   <= 1'b0;
        frameErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_mod_cfg.sv
module serial_mod_cfg
  import smc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int A_MAX = 5,
  parameter int M_MIN = 41,
  parameter int M_MAX = 103
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgSclk,
  input  logic       cfgSdata,
  input  logic       cfgSen,
  output logic [2:0] presA,
  output logic [6:0] fbM,
  output logic       synthEn,
  output logic       pumpHi,
  output logic       triDis,
  output logic [5:0] atten,
  output logic       filterOff,
  output logic       wordOk,
  output logic       frameErr
);
  strobe_t strobes;
  cfg_t    cfg;

  smc_ctrl #(.SYNC_STAGES(SYNC_STAGES), .FRAME_BITS(WORD_LEN)) ctrl_i (
    .clk(clk), .rst(rst), .sclkIn(cfgSclk), .sdataIn(cfgSdata),
    .senIn(cfgSen), .strobes(strobes)
  );

  smc_dp #(.A_MAX(A_MAX), .M_MIN(M_MIN), .M_MAX(M_MAX)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .cfg(cfg),
    .wordOk(wordOk), .frameErr(frameErr)
  );

  assign presA     = cfg.presA;
  assign fbM       = cfg.fbM;
  assign synthEn   = cfg.synthEn;
  assign pumpHi    = cfg.pumpHi;
  assign triDis    = cfg.triDis;
  assign atten     = cfg.atten;
  assign filterOff = cfg.filterOff;
endmodule

// File: rtl/smc_chk.sv
module smc_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfgSen,
  input logic [2:0] presA,
  input logic [6:0] fbM,
  input logic       synthEn,
  input logic       pumpHi,
  input logic       triDis,
  input logic [5:0] atten,
  input logic       filterOff,
  input logic       wordOk,
  input logic       frameErr
);
  logic [19:0] cfgBus;
  assign cfgBus = {presA, fbM, synthEn, pumpHi, triDis, atten, filterOff};

  // R1
  reset_default_chk: assert property (@(posedge clk)
    rst |=> (cfgBus == '0 && !wordOk && !frameErr));

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(wordOk && frameErr));

  // R6
  frame_err_clears_ok_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frameErr) |-> !wordOk);

  // R7
  held_a_legal_chk: assert property (@(posedge clk) disable iff (rst)
    wordOk |-> presA <= 3'd5);

  // R8
  held_m_legal_chk: assert property (@(posedge clk) disable iff (rst)
    wordOk |-> (fbM >= 7'd41 && fbM <= 7'd103));

  // R10
  cfg_change_needs_ok_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfgBus) |-> (wordOk && !frameErr));

  // R5
  no_update_while_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfgSen, 2) |=> $stable(cfgBus));
endmodule

bind serial_mod_cfg smc_chk chk_i (.*);

// File: tb/serial_mod_cfg_tb.sv
module serial_mod_cfg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgSclk = 1'b0, cfgSdata = 1'b0, cfgSen = 1'b0;
  logic [2:0] presA;
  logic [6:0] fbM;
  logic synthEn, pumpHi, triDis, filterOff, wordOk, frameErr;
  logic [5:0] atten;

  always #5 clk = ~clk;

  serial_mod_cfg dut_i (
    .clk(clk), .rst(rst), .cfgSclk(cfgSclk), .cfgSdata(cfgSdata),
    .cfgSen(cfgSen), .presA(presA), .fbM(fbM), .synthEn(synthEn),
    .pumpHi(pumpHi), .triDis(triDis), .atten(atten),
    .filterOff(filterOff), .wordOk(wordOk), .frameErr(frameErr)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [2:0] inQ[$];
  bit prevClk, prevEn;
  int nBits;
  bit word[23];
  int mA, mM, mAtt;
  bit mSe, mPh, mTd, mFo, mOk, mErr;

  always @(posedge clk) begin
    if (rst) begin
      inQ = '{3'b000, 3'b000};
      prevClk = 0; prevEn = 0; nBits = 0;
      mA = 0; mM = 0; mAtt = 0; mSe = 0; mPh = 0; mTd = 0; mFo = 0;
      mOk = 0; mErr = 0;
    end else begin
      bit [2:0] cur;
      cur = inQ.pop_front();
      inQ.push_back({cfgSclk, cfgSdata, cfgSen});
      if (prevEn && !cur[0]) begin
        if (nBits == 23) begin
          int a, m, r, att;
          a = 0; m = 0; r = 0; att = 0;
          for (int i = 0; i < 3; i++) a += word[i] << i;
          for (int i = 0; i < 7; i++) m += word[3+i] << i;
          for (int i = 0; i < 6; i++) att += word[13+i] << i;
          for (int i = 0; i < 3; i++) r += word[19+i] << i;
          mOk = (a <= 5) && (m >= 41) && (m <= 103) && (r == 0);
          if (mOk) begin
            mA = a; mM = m; mAtt = att; mSe = word[10]; mPh = word[11];
            mTd = word[12]; mFo = word[22];
          end
          mErr = 0;
        end else begin
          mErr = 1; mOk = 0;
        end
        nBits = 0;
      end else if (cur[0] && prevClk && !cur[2]) begin
        if (nBits < 23) word[nBits] = cur[1];
        nBits++;
      end
      prevClk = cur[2];
      prevEn = cur[0];
    end
  end

  always @(negedge clk) if (!rst && !finished) begin
    chk("R4 model presA", presA, mA);
    chk("R4 model fbM", fbM, mM);
    chk("R4 model atten", atten, mAtt);
    chk("R4 model bits", {synthEn, pumpHi, triDis, filterOff}, {mSe, mPh, mTd, mFo});
    chk("R10 model wordOk", wordOk, mOk);
    chk("R6 model frameErr", frameErr, mErr);
  end

  function automatic logic [22:0] mk(int a, int m, bit se, bit ph, bit td,
                                     int att, int rsv, bit fo);
    return {fo, 3'(rsv), 6'(att), td, ph, se, 7'(m), 3'(a)};
  endfunction

  task automatic shiftBits(logic [22:0] w, int n);
    @(negedge clk) cfgSen = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      cfgSdata = (i < 23) ? w[i] : 1'b0;
      cfgSclk = 1;
      repeat (2) @(negedge clk);
      cfgSclk = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic endFrame();
    cfgSen = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic sendWord(logic [22:0] w, int n);
    shiftBits(w, n);
    endFrame();
  endtask

  task automatic expectCfg(string tag, int a, int m, bit se, bit ph, bit td,
                           int att, bit fo, bit ok, bit err);
    chk({tag, " presA"}, presA, a);
    chk({tag, " fbM"}, fbM, m);
    chk({tag, " synthEn"}, synthEn, se);
    chk({tag, " pumpHi"}, pumpHi, ph);
    chk({tag, " triDis"}, triDis, td);
    chk({tag, " atten"}, atten, att);
    chk({tag, " filterOff"}, filterOff, fo);
    chk({tag, " wordOk"}, wordOk, ok);
    chk({tag, " frameErr"}, frameErr, err);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    expectCfg("R1 in reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    expectCfg("R1 after reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R3 R4 R10: A=1 detects reversed order
    sendWord(mk(1, 50, 1, 1, 0, 4, 0, 0), 23);
    expectCfg("R3 R4 R10 legal", 1, 50, 1, 1, 0, 4, 0, 1, 0);

    // R7
    sendWord(mk(6, 60, 0, 0, 1, 9, 0, 1), 23);
    expectCfg("R7 A=6", 1, 50, 1, 1, 0, 4, 0, 0, 0);
    sendWord(mk(5, 103, 0, 1, 1, 33, 0, 0), 23);
    expectCfg("R7 R8 A=5 M=103", 5, 103, 0, 1, 1, 33, 0, 1, 0);

    // R8
    sendWord(mk(2, 40, 1, 0, 0, 1, 0, 0), 23);
    expectCfg("R8 M=40", 5, 103, 0, 1, 1, 33, 0, 0, 0);
    sendWord(mk(2, 104, 1, 0, 0, 1, 0, 0), 23);
    expectCfg("R8 M=104", 5, 103, 0, 1, 1, 33, 0, 0, 0);
    sendWord(mk(0, 41, 1, 0, 0, 2, 0, 0), 23);
    expectCfg("R8 M=41", 0, 41, 1, 0, 0, 2, 0, 1, 0);

    // R9
    sendWord(mk(3, 70, 0, 1, 1, 7, 4, 1), 23);
    expectCfg("R9 reserved", 0, 41, 1, 0, 0, 2, 0, 0, 0);

    // R6
    sendWord(mk(3, 70, 0, 1, 1, 7, 0, 1), 22);
    expectCfg("R6 22 bits", 0, 41, 1, 0, 0, 2, 0, 0, 1);
    sendWord(mk(3, 70, 0, 1, 1, 7, 0, 1), 24);
    expectCfg("R6 24 bits", 0, 41, 1, 0, 0, 2, 0, 0, 1);

    // R2: clocking with enable low
    for (int i = 0; i < 30; i++) begin
      cfgSdata = i[0];
      cfgSclk = 1; repeat (2) @(negedge clk);
      cfgSclk = 0; repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    expectCfg("R2 enable low", 0, 41, 1, 0, 0, 2, 0, 0, 1);

    // R5: full word shifted, enable still high
    shiftBits(mk(4, 90, 1, 0, 1, 63, 0, 1), 23);
    repeat (6) @(negedge clk);
    expectCfg("R5 before enable fall", 0, 41, 1, 0, 0, 2, 0, 0, 1);
    endFrame();
    expectCfg("R4 R10 after enable fall", 4, 90, 1, 0, 1, 63, 1, 1, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule